// File: doc/BRIEF.md
# Timer Compare Output Waveform Generator

An 8-bit timer with two compare channels, each of which can take over an output pin and drive a waveform on it. The counter advances by one on every clock and runs in one of three counting schemes: free-running, clear-on-match, or single-slope PWM. Each channel compares the count against its own compare value. On a match, and in PWM at the wrap to zero, the channel sets, clears or toggles a waveform bit. Which of these it does depends on a 2-bit output mode field and on the counting scheme.

Software reaches the block through a small register port: a write strobe, an address, write data, and combinational read data. The pin logic takes a port data bit and a direction bit for each channel. When a channel's mode takes the pin, the waveform bit replaces the port data. The output enable always follows the direction bit.

Top module: `tmr_wavegen`

## Requirements
- R1: After reset every register reads 0, both pins are low and both enables are low. The address map is: 0 control (channel A mode in bits 7:6, channel B mode in bits 5:4, scheme-select low bits in 1:0, bits 3:2 always read 0); 1 extension (bit 0 is scheme-select bit 2, other bits read 0); 2 count; 3 compare A; 4 compare B; 5 port data (bit 0 is A, bit 1 is B); 6 direction (same bit order); 7 reads 0.
- R2: The 3-bit scheme select {ext[0], ctrl[1:0]} works as follows. 010 clears the count on the clock after it equals the active compare A value. 011 is PWM with TOP = 0xFF. 111 is PWM with TOP = active compare A. Every other code counts freely and wraps from 0xFF to 0. A write to address 2 loads the count.
- R3: Outside PWM, on a compare match, mode 01 toggles the waveform bit, 10 clears it and 11 sets it.
- R4: In PWM, mode 10 clears the bit on match and sets it on the clock where the count leaves TOP for 0. Mode 11 does the reverse.
- R5: In PWM, mode 01 releases the pin when scheme bit 2 is 0. When that bit is 1, mode 01 takes the pin and toggles on match.
- R6: In PWM with mode 10 or 11, a compare value equal to TOP produces no match action, and only the wrap action applies.
- R7: A channel in mode 00 (or released under R5) shows its port data bit on its pin.
- R8: Each pin's enable equals its direction bit, whatever the mode.
- R9: Compare writes read back at once. Outside PWM they act at once. In PWM they act only from the clock where the count leaves TOP.
- R10: A mode write changes the pin source from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_out | output | 2 | Pin values, bit 0 channel A |
| pin_oe | output | 2 | Pin output enables |

## Verification
A wrong waveform bit stays in its register until the next match or wrap event rewrites it. It therefore shows on the pin on the very next clock and stays wrong for up to a whole counter period. This is why the pins are compared against a model on every cycle, not sampled at a few points. A wrong count or a wrongly adopted compare value moves every later match, so the count is read back on every cycle. A buffering error in PWM becomes visible only in the period right after the write, and the sweep writes in the middle of a period to expose it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int N_CH   = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_EXT   = 3'd1,
        REG_CNT   = 3'd2,
        REG_CMP_A = 3'd3,
        REG_CMP_B = 3'd4,
        REG_PDATA = 3'd5,
        REG_PDIR  = 3'd6,
        REG_NONE  = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        OUT_OFF = 2'd0,
        OUT_TOG = 2'd1,
        OUT_CLR = 2'd2,
        OUT_SET = 2'd3
    } out_mode_e;

    typedef enum logic [1:0] {
        WF_NORMAL,
        WF_CTC,
        WF_PWM_MAX,
        WF_PWM_CMP
    } wave_sel_e;

    typedef struct packed {
        out_mode_e  mode_a;
        out_mode_e  mode_b;
        logic [1:0] rsvd;
        logic [1:0] wg_lo;
    } ctrl_t;

    typedef struct packed {
        logic match;
        logic at_top;
        logic cmp_is_top;
    } cmp_evt_t;

    function automatic wave_sel_e decode_wave(logic wg_hi, logic [1:0] wg_lo);
        case ({wg_hi, wg_lo})
            3'b010:  return WF_CTC;
            3'b011:  return WF_PWM_MAX;
            3'b111:  return WF_PWM_CMP;
            default: return WF_NORMAL;
        endcase
    endfunction

    function automatic logic is_pwm(wave_sel_e ws);
        return (ws == WF_PWM_MAX) || (ws == WF_PWM_CMP);
    endfunction

    function automatic logic top_from_cmp(wave_sel_e ws);
        return (ws == WF_CTC) || (ws == WF_PWM_CMP);
    endfunction

    function automatic logic pin_owned(wave_sel_e ws, logic wg_hi, out_mode_e m);
        if (m == OUT_OFF)
            return 1'b0;
        if (is_pwm(ws) && (m == OUT_TOG) && !wg_hi)
            return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic next_wave(wave_sel_e ws, logic wg_hi, out_mode_e m,
                                       cmp_evt_t ev, logic cur);
        logic nxt;
        logic hit;
        nxt = cur;
        hit = ev.match;
        if (!is_pwm(ws)) begin
            case (m)
                OUT_TOG: if (hit) nxt = ~cur;
                OUT_CLR: if (hit) nxt = 1'b0;
                OUT_SET: if (hit) nxt = 1'b1;
                default: nxt = cur;
            endcase
        end else begin
            if (((m == OUT_CLR) || (m == OUT_SET)) && ev.cmp_is_top)
                hit = 1'b0;
            case (m)
                OUT_TOG: if (wg_hi && hit) nxt = ~cur;
                OUT_CLR: begin
                    if (hit)            nxt = 1'b0;
                    else if (ev.at_top) nxt = 1'b1;
                end
                OUT_SET: begin
                    if (hit)            nxt = 1'b1;
                    else if (ev.at_top) nxt = 1'b0;
                end
                default: nxt = cur;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NC = N_CH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl_q,
    output logic          wg_hi_q,
    output logic [NC-1:0] pdata_q,
    output logic [NC-1:0] pdir_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            wg_hi_q <= 1'b0;
            pdata_q <= '0;
            pdir_q  <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                REG_CTRL: begin
                    ctrl_q      <= ctrl_t'(wdata[7:0]);
                    ctrl_q.rsvd <= 2'b00;
                end
                REG_EXT:   wg_hi_q <= wdata[0];
                REG_PDATA: pdata_q <= wdata[NC-1:0];
                REG_PDIR:  pdir_q  <= wdata[NC-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] top_val,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic         at_top
);

    assign at_top = (cnt_q == top_val);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (at_top)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + W'(1);
    end

endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  wave_sel_e    ws,
    input  logic         wg_hi,
    input  out_mode_e    mode,
    input  logic [W-1:0] cnt,
    input  logic         at_top,
    input  logic [W-1:0] top_val,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    input  logic         pdata,
    input  logic         pdir,
    output logic [W-1:0] buf_q,
    output logic [W-1:0] act_q,
    output logic         wave_q,
    output logic         pin_o,
    output logic         pin_oe
);

    cmp_evt_t ev;
    logic     pwm;

    assign pwm           = is_pwm(ws);
    assign ev.match      = (cnt == act_q);
    assign ev.at_top     = at_top;
    assign ev.cmp_is_top = (act_q == top_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            act_q  <= '0;
            wave_q <= 1'b0;
        end else begin
            if (wr)
                buf_q <= wr_val;
            if (wr && !pwm)
                act_q <= wr_val;
            else if (pwm && at_top)
                act_q <= buf_q;
            wave_q <= next_wave(ws, wg_hi, mode, ev, wave_q);
        end
    end

    assign pin_o  = pin_owned(ws, wg_hi, mode) ? wave_q : pdata;
    assign pin_oe = pdir;

endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen
    import tmr_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_CH-1:0]   pin_out,
    output logic [N_CH-1:0]   pin_oe
);

    ctrl_t            ctrl_q;
    logic             wg_hi;
    logic [N_CH-1:0]  pdata_q;
    logic [N_CH-1:0]  pdir_q;
    wave_sel_e        ws;
    logic [CNT_W-1:0] cnt;
    logic             at_top;
    logic [CNT_W-1:0] top_val;
    logic [CNT_W-1:0] buf_q [N_CH];
    logic [CNT_W-1:0] act_q [N_CH];
    logic [N_CH-1:0]  wave;
    logic [CNT_W-1:0] act_a;
    logic [1:0]       mode_a;

    tmr_regs #(.DW(DATA_W), .AW(ADDR_W), .NC(N_CH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .wg_hi_q (wg_hi),
        .pdata_q (pdata_q),
        .pdir_q  (pdir_q)
    );

    assign ws      = decode_wave(wg_hi, ctrl_q.wg_lo);
    assign act_a   = act_q[0];
    assign mode_a  = ctrl_q.mode_a;
    assign top_val = top_from_cmp(ws) ? act_a : '1;

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .top_val  (top_val),
        .load     (bus_we && (reg_addr_e'(bus_addr) == REG_CNT)),
        .load_val (CNT_W'(bus_wdata)),
        .cnt_q    (cnt),
        .at_top   (at_top)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        localparam logic [ADDR_W-1:0] CMP_ADDR = ADDR_W'(int'(REG_CMP_A) + ch);
        out_mode_e ch_mode;
        if (ch == 0) begin : g_a
            assign ch_mode = ctrl_q.mode_a;
        end else begin : g_b
            assign ch_mode = ctrl_q.mode_b;
        end

        tmr_cmp_unit #(.W(CNT_W)) u_cmp (
            .clk     (clk),
            .rst     (rst),
            .ws      (ws),
            .wg_hi   (wg_hi),
            .mode    (ch_mode),
            .cnt     (cnt),
            .at_top  (at_top),
            .top_val (top_val),
            .wr      (bus_we && (bus_addr == CMP_ADDR)),
            .wr_val  (CNT_W'(bus_wdata)),
            .pdata   (pdata_q[ch]),
            .pdir    (pdir_q[ch]),
            .buf_q   (buf_q[ch]),
            .act_q   (act_q[ch]),
            .wave_q  (wave[ch]),
            .pin_o   (pin_out[ch]),
            .pin_oe  (pin_oe[ch])
        );
    end

    always_comb begin
        case (reg_addr_e'(bus_addr))
            REG_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            REG_EXT:   bus_rdata = DATA_W'(wg_hi);
            REG_CNT:   bus_rdata = DATA_W'(cnt);
            REG_CMP_A: bus_rdata = DATA_W'(buf_q[0]);
            REG_CMP_B: bus_rdata = DATA_W'(buf_q[1]);
            REG_PDATA: bus_rdata = DATA_W'(pdata_q);
            REG_PDIR:  bus_rdata = DATA_W'(pdir_q);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_wavegen_chk.sv
module tmr_wavegen_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [N_CH-1:0]   pin_out,
    input logic [N_CH-1:0]   pin_oe,
    input logic [CNT_W-1:0]  cnt,
    input logic [1:0]        ws,
    input logic [CNT_W-1:0]  act_a,
    input logic [CNT_W-1:0]  top_val,
    input logic [N_CH-1:0]   wave,
    input logic [1:0]        mode_a
);

    logic cnt_wr;
    logic pwm;
    assign cnt_wr = bus_we && (bus_addr == REG_CNT);
    assign pwm    = (ws == WF_PWM_MAX) || (ws == WF_PWM_CMP);

    assert_free_run_R2: assert property (@(posedge clk) disable iff (rst)
        (ws == WF_NORMAL) && !cnt_wr |=> cnt == $past(cnt) + CNT_W'(1));

    assert_ctc_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (ws == WF_CTC) && (cnt == act_a) && !cnt_wr |=> cnt == '0);

    assert_match_set_R3: assert property (@(posedge clk) disable iff (rst)
        !pwm && (mode_a == OUT_SET) && (cnt == act_a) |=> wave[0]);

    assert_wrap_set_R4: assert property (@(posedge clk) disable iff (rst)
        pwm && (mode_a == OUT_CLR) && (cnt == top_val) |=> wave[0]);

    assert_top_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        pwm && mode_a[1] && (act_a == top_val) && (cnt != top_val) |=> $stable(wave[0]));

    assert_port_data_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_a == OUT_OFF) && bus_we && (bus_addr == REG_PDATA)
        |=> pin_out[0] == $past(bus_wdata[0]));

    assert_dir_enable_R8: assert property (@(posedge clk) disable iff (rst)
        bus_we && (bus_addr == REG_PDIR) |=> pin_oe == $past(bus_wdata[N_CH-1:0]));

endmodule

bind tmr_wavegen tmr_wavegen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .cnt       (cnt),
    .ws        (ws),
    .act_a     (act_a),
    .top_val   (top_val),
    .wave      (wave),
    .mode_a    (mode_a)
);

// File: tb/tmr_wavegen_tb.sv
`timescale 1ns/100ps
module tmr_wavegen_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       we;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [1:0] pin_out;
    logic [1:0] pin_oe;

    always #4 clk = ~clk;

    tmr_wavegen u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] m_ctrl, m_ext, m_cnt, m_pd, m_dir;
    logic [7:0] m_buf [2];
    logic [7:0] m_act [2];
    logic [1:0] m_wave;
    int         mis_pin, mis_cnt;
    logic [3:0] bad_pin_got, bad_pin_exp;
    logic [7:0] bad_cnt_got, bad_cnt_exp;

    task automatic check(input bit ok, input string tag, input string what,
                         input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [2:0] m_wg();
        return {m_ext[0], m_ctrl[1:0]};
    endfunction

    function automatic bit m_pwm();
        return (m_wg() == 3'b011) || (m_wg() == 3'b111);
    endfunction

    function automatic logic [1:0] m_mode(int ch);
        return (ch == 0) ? m_ctrl[7:6] : m_ctrl[5:4];
    endfunction

    function automatic logic [1:0] m_pins();
        logic [1:0] p;
        for (int ch = 0; ch < 2; ch++) begin
            logic [1:0] md;
            bit own;
            md  = m_mode(ch);
            own = (md != 2'b00) && !(m_pwm() && md == 2'b01 && !m_ext[0]);
            p[ch] = own ? m_wave[ch] : m_pd[ch];
        end
        return p;
    endfunction

    task automatic model_reset();
        m_ctrl = 0; m_ext = 0; m_cnt = 0; m_pd = 0; m_dir = 0; m_wave = 0;
        for (int ch = 0; ch < 2; ch++) begin
            m_buf[ch] = 0;
            m_act[ch] = 0;
        end
    endtask

    task automatic model_step(input bit w, input logic [2:0] a, input logic [7:0] d);
        logic [2:0] g;
        bit         pwm, from_cmp, attop;
        logic [7:0] top;
        logic [1:0] nw;
        logic [7:0] na [2];
        g        = m_wg();
        pwm      = m_pwm();
        from_cmp = (g == 3'b010) || (g == 3'b111);
        top      = from_cmp ? m_act[0] : 8'hFF;
        attop    = (m_cnt == top);
        nw       = m_wave;
        for (int ch = 0; ch < 2; ch++) begin
            logic [1:0] md;
            bit hit;
            md  = m_mode(ch);
            hit = (m_cnt == m_act[ch]);
            na[ch] = m_act[ch];
            if (!pwm) begin
                if (hit && md == 2'b01) nw[ch] = ~m_wave[ch];
                if (hit && md == 2'b10) nw[ch] = 1'b0;
                if (hit && md == 2'b11) nw[ch] = 1'b1;
            end else begin
                if (md[1] && m_act[ch] == top) hit = 0;
                if (md == 2'b01 && g[2] && hit) nw[ch] = ~m_wave[ch];
                if (md == 2'b10) nw[ch] = hit ? 1'b0 : (attop ? 1'b1 : m_wave[ch]);
                if (md == 2'b11) nw[ch] = hit ? 1'b1 : (attop ? 1'b0 : m_wave[ch]);
            end
            if (w && a == 3'(3 + ch) && !pwm) na[ch] = d;
            else if (pwm && attop)            na[ch] = m_buf[ch];
        end
        if (w && a == 3'd2)  m_cnt = d;
        else if (attop)      m_cnt = 8'h00;
        else                 m_cnt = m_cnt + 8'd1;
        m_wave = nw;
        for (int ch = 0; ch < 2; ch++) m_act[ch] = na[ch];
        if (w) begin
            case (a)
                3'd0: m_ctrl   = d & 8'hF3;
                3'd1: m_ext    = d & 8'h01;
                3'd3: m_buf[0] = d;
                3'd4: m_buf[1] = d;
                3'd5: m_pd     = d & 8'h03;
                3'd6: m_dir    = d & 8'h03;
                default: ;
            endcase
        end
    endtask

    // one clock: drive at the falling edge, compare at the next falling edge
    task automatic cyc(input bit w, input logic [2:0] a, input logic [7:0] d);
        we = w; addr = a; wdata = d;
        model_step(w, a, d);
        @(posedge clk);
        #1;
        we = 1'b0; addr = 3'd2; wdata = 8'h00;
        @(negedge clk);
        if ({pin_oe, pin_out} != {m_dir[1:0], m_pins()}) begin
            if (mis_pin == 0) begin
                bad_pin_got = {pin_oe, pin_out};
                bad_pin_exp = {m_dir[1:0], m_pins()};
            end
            mis_pin++;
        end
        if (rdata != m_cnt) begin
            if (mis_cnt == 0) begin
                bad_cnt_got = rdata;
                bad_cnt_exp = m_cnt;
            end
            mis_cnt++;
        end
    endtask

    task automatic run_until(input logic [7:0] c);
        for (int i = 0; i < 600 && m_cnt != c; i++) cyc(0, 3'd2, 8'h00);
    endtask

    function automatic string tag_of(logic [2:0] g, int c, int variant);
        bit pwm;
        pwm = (g == 3'b011) || (g == 3'b111);
        if (c == 0)              return "R7";
        if (!pwm)                return "R3";
        if (variant == 1)        return "R6";
        if (c == 1)              return "R5";
        return "R4";
    endfunction

    task automatic read_chk(input logic [2:0] a, input logic [7:0] exp, input string what);
        addr = a;
        #1;
        check(rdata == exp, "R1", what, rdata, exp);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] wgs [4];
        wgs[0] = 3'b000; wgs[1] = 3'b010; wgs[2] = 3'b011; wgs[3] = 3'b111;
        rst = 1'b1; we = 1'b0; addr = 3'd0; wdata = 8'h00;
        mis_pin = 0; mis_cnt = 0;
        bad_pin_got = 0; bad_pin_exp = 0; bad_cnt_got = 0; bad_cnt_exp = 0;
        model_reset();
        repeat (3) @(negedge clk);

        // R1: reset values, pins quiet
        for (int a = 0; a < 8; a++) read_chk(3'(a), 8'h00, "reset readback");
        check({pin_oe, pin_out} == 4'h0, "R1", "reset pins", {pin_oe, pin_out}, 0);
        addr = 3'd2;
        @(negedge clk);
        rst = 1'b0;

        // R1: reserved control bits and extension upper bits read zero
        cyc(1, 3'd0, 8'h0C);
        read_chk(3'd0, 8'h00, "ctrl reserved bits");
        addr = 3'd2;
        cyc(1, 3'd1, 8'hFE);
        read_chk(3'd1, 8'h00, "ext upper bits");
        addr = 3'd2;

        // R8: enable follows direction with no mode set
        cyc(1, 3'd6, 8'h02);
        check(pin_oe == 2'b10, "R8", "oe from dir", pin_oe, 2'b10);
        // R7: port data shown while disconnected
        cyc(1, 3'd5, 8'h03);
        check(pin_out == 2'b11, "R7", "port data", pin_out, 2'b11);
        // R10: mode write switches source on the storing edge (wave A is 0)
        cyc(1, 3'd0, 8'h80);
        check(pin_out[0] == 1'b0, "R10", "pin A after mode write", pin_out[0], 0);
        check(pin_oe == 2'b10, "R8", "oe unchanged by mode", pin_oe, 2'b10);

        // R9: buffered compare in PWM, TOP = 0xFF, channel A clear-on-match
        cyc(1, 3'd6, 8'h03);
        cyc(1, 3'd0, 8'h83);
        cyc(1, 3'd3, 8'h80);
        run_until(8'h10);
        cyc(1, 3'd2, 8'hF0);
        run_until(8'h10);
        cyc(1, 3'd3, 8'h20);
        read_chk(3'd3, 8'h20, "cmp readback R9");
        addr = 3'd2;
        run_until(8'h30);
        check(pin_out[0] == 1'b1, "R9", "old compare still active", pin_out[0], 1);
        run_until(8'h10);
        run_until(8'h30);
        check(pin_out[0] == 1'b0, "R9", "new compare active", pin_out[0], 0);

        // sweep every scheme and mode pair against the cycle model
        for (int gi = 0; gi < 4; gi++) begin
            for (int c = 0; c < 4; c++) begin
                for (int v = 0; v < 2; v++) begin
                    logic [2:0] g;
                    logic [7:0] ca, cb;
                    string tg;
                    g  = wgs[gi];
                    ca = (v == 1) ? ((g == 3'b011) ? 8'hFF : 8'h90) : 8'h60;
                    cb = (v == 1) ? ca : 8'h20;
                    tg = tag_of(g, c, v);
                    mis_pin = 0; mis_cnt = 0;
                    cyc(1, 3'd6, 8'h03);
                    cyc(1, 3'd5, (c[0]) ? 8'h02 : 8'h01);
                    cyc(1, 3'd1, {7'd0, g[2]});
                    cyc(1, 3'd0, {2'(c), 2'(3 - c), 2'b00, g[1:0]});
                    cyc(1, 3'd3, ca);
                    cyc(1, 3'd4, cb);
                    cyc(1, 3'd2, 8'h00);
                    for (int i = 0; i < 560; i++) begin
                        if (i == 280 && v == 0) cyc(1, 3'd4, 8'h30);
                        else                    cyc(0, 3'd2, 8'h00);
                    end
                    check(mis_pin == 0, tg, $sformatf("pins scheme %0d mode %0d set %0d", g, c, v),
                          bad_pin_got, bad_pin_exp);
                    check(mis_cnt == 0, "R2", $sformatf("count scheme %0d", g),
                          bad_cnt_got, bad_cnt_exp);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule